// File: doc/BRIEF.md
# Serial Port Register Block

This block is the software-visible register file of an asynchronous serial port. A host reaches it over a plain synchronous register bus. The bus has an address, a write strobe with write data, and a read strobe with combinational read data. The block holds the frame-mode, bit-rate, control and pin-port settings and a sticky status register. It passes each byte written to the transmit-data offset on to the transmit shifter as a one-cycle strobe.

On the line side the block takes single-cycle event pulses: break detected, transmission complete, receive FIFO reached its trigger level, and receive data ready. Each pulse sets a status flag. Software clears a flag by writing a zero to its bit; a one leaves the flag as it is. Two outputs come from the control register: the transmit-interrupt line and the receive-enable level. The receive-interrupt line is raised by a trigger event when the receive interrupt is enabled.

The baud generator, the shift registers and the receive FIFO storage sit outside this block.

Top module: `serport_regs`

## Requirements
- R1: After reset, the registers read as follows: mode 0x00, bit rate 0xFF, control 0x20, pin port 0x00 and status 0x60. The outputs `tx_irq`, `rx_irq`, `rx_en` and `tx_stb` are all low.
- R2: A write keeps only some bits of each register. Mode (offset 0x00) keeps the bits in mask 0x7B. Bit rate (0x04) keeps all 8 bits. Control (0x08) keeps mask 0xFA. Pin port (0x20) keeps mask 0xF3. Each reads back at its own offset.
- R3: A control write with bit 5 (transmit enable) equal to 0 sets the transmit-end flag (status bit 6).
- R4: After each control write, `tx_irq` equals written bit 7. A control write with bit 6 (receive-interrupt enable) equal to 0 drops `rx_irq`.
- R5: A write to offset 0x0C raises `tx_stb` for exactly the next cycle. `tx_byte` carries the written byte and holds it afterwards. The write clears the transmit-empty flag (status bit 5).
- R6: Status sits at offset 0x10 with this layout: bit 6 transmit end, bit 5 transmit empty, bit 4 break, bit 1 FIFO trigger reached, bit 0 data ready. Bits 7, 3 and 2 read 0. A status write clears every listed flag whose bit is 0 and leaves the others unchanged.
- R7: A `rx_trig` pulse sets bit 1. If control bit 6 is 1 at that time, the pulse also raises `rx_irq`. A status write with bit 1 or bit 0 equal to 0 drops `rx_irq`.
- R8: A status read returns the flags as they stood before the read. If control bit 5 is 1 at the read, bits 5 and 6 are set in the cycle after it. If control bit 5 is 0, the read leaves them unchanged.
- R9: Three line-side pulses each set one flag: `line_break` sets bit 4, `tx_done` sets bit 6 and `rx_dready` sets bit 0.
- R10: Offset 0x24, the transmit-data offset 0x0C and every unmapped offset read as 0. Writes to 0x24 and to unmapped offsets change no register or flag.
- R11: When a flag-setting event and a status write that would clear that flag fall in the same cycle, the flag ends up set.
- R12: `rx_en` equals control bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe; a status read has a side effect |
| reg_rdata | output | 8 | Read data, combinational, zero when no read |
| tx_stb | output | 1 | One-cycle transmit byte strobe |
| tx_byte | output | 8 | Last byte written for transmission |
| tx_irq | output | 1 | Transmit interrupt, follows control bit 7 |
| rx_irq | output | 1 | Receive interrupt |
| rx_en | output | 1 | Receive enable, control bit 4 |
| line_break | input | 1 | Break-detected pulse |
| tx_done | input | 1 | Transmission-complete pulse |
| rx_trig | input | 1 | Receive FIFO reached trigger pulse |
| rx_dready | input | 1 | Receive data-ready pulse |

## Verification
Some properties are checked on every cycle, whatever the stimulus:
- break and transmit-complete pulses always leave their flags set, even against a clearing write (R9, R11);
- a status read with transmit enabled always re-arms the two transmit flags;
- the reserved status bits and the mode bits outside the mask always read as zero;
- every transmit-data write yields a strobe carrying its byte;
- both control outputs track the last control write.

Other behaviour needs an ordered scenario, and only the bench shows it:
- the value a status read returns against the re-armed value seen on the next read;
- flag-by-flag clearing across a series of write-zero patterns;
- the strobe falling after exactly one cycle;
- writes to unmapped offsets leaving every register intact.

// File: rtl/serport_pkg.sv
package serport_pkg;

  localparam int REG_W  = 8;
  localparam int NCFG   = 4;
  localparam int NFLAG  = 5;

  // register byte offsets
  localparam logic [7:0] OFF_MODE = 8'h00;
  localparam logic [7:0] OFF_RATE = 8'h04;
  localparam logic [7:0] OFF_CTRL = 8'h08;
  localparam logic [7:0] OFF_TXD  = 8'h0C;
  localparam logic [7:0] OFF_STAT = 8'h10;
  localparam logic [7:0] OFF_PIN  = 8'h20;
  localparam logic [7:0] OFF_LINE = 8'h24;

  // configuration registers: index 0 mode, 1 rate, 2 ctrl, 3 pin
  localparam int CFG_MODE = 0;
  localparam int CFG_RATE = 1;
  localparam int CFG_CTRL = 2;
  localparam int CFG_PIN  = 3;

  localparam logic [NCFG-1:0][7:0] CFG_OFF  = {OFF_PIN, OFF_CTRL, OFF_RATE, OFF_MODE};
  localparam logic [NCFG-1:0][7:0] CFG_MASK = {8'hF3, 8'hFA, 8'hFF, 8'h7B};
  localparam logic [NCFG-1:0][7:0] CFG_RST  = {8'h00, 8'h20, 8'hFF, 8'h00};

  // control bit positions
  localparam int CB_TIE = 7;
  localparam int CB_RIE = 6;
  localparam int CB_TE  = 5;
  localparam int CB_RE  = 4;

  // status flag indices and their bit positions in the status byte
  localparam int FL_DR   = 0;
  localparam int FL_RDF  = 1;
  localparam int FL_BRK  = 2;
  localparam int FL_TDE  = 3;
  localparam int FL_TEND = 4;

  localparam logic [NFLAG-1:0][2:0] FLAG_POS = {3'd6, 3'd5, 3'd4, 3'd1, 3'd0};
  localparam logic [NFLAG-1:0]      FLAG_RST = 5'b11000;

endpackage

// File: rtl/serport_mreg.sv
module serport_mreg #(
  parameter int          W    = 8,
  parameter logic [W-1:0] MASK = '1,
  parameter logic [W-1:0] RST  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic [W-1:0] q_n;

  always_comb begin
    q_n = q;
    if (we) q_n = wdata & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST;
    else        q <= q_n;
  end

endmodule

// File: rtl/serport_txdata.sv
module serport_txdata #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic         tx_stb,
  output logic [W-1:0] tx_byte
);

  logic         stb_n;
  logic [W-1:0] byte_n;

  always_comb begin
    stb_n  = we;
    byte_n = tx_byte;
    if (we) byte_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_stb  <= 1'b0;
      tx_byte <= '0;
    end else begin
      tx_stb  <= stb_n;
      tx_byte <= byte_n;
    end
  end

  AST_TX_STROBE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (tx_stb && tx_byte == $past(wdata))); // R5

endmodule

// File: rtl/serport_status.sv
module serport_status
  import serport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stat_wr,
  input  logic       stat_rd,
  input  logic [7:0] wdata,
  input  logic       ctrl_wr,
  input  logic       txd_wr,
  input  logic       ctrl_te,
  input  logic       ctrl_rie,
  input  logic       line_break,
  input  logic       tx_done,
  input  logic       rx_trig,
  input  logic       rx_dready,
  output logic [7:0] stat_byte,
  output logic       rx_irq
);

  logic [NFLAG-1:0] flag_q;
  logic [NFLAG-1:0] flag_n;
  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] clr_v;
  logic             rearm;
  logic             irq_set;
  logic             irq_clr;
  logic             irq_n;

  assign rearm = stat_rd & ctrl_te;

  always_comb begin
    set_v          = '0;
    set_v[FL_TEND] = (ctrl_wr & ~wdata[CB_TE]) | tx_done | rearm;
    set_v[FL_TDE]  = rearm;
    set_v[FL_BRK]  = line_break;
    set_v[FL_RDF]  = rx_trig;
    set_v[FL_DR]   = rx_dready;

    clr_v = '0;
    for (int i = 0; i < NFLAG; i++) begin
      clr_v[i] = stat_wr & ~wdata[FLAG_POS[i]];
    end
    clr_v[FL_TDE] = clr_v[FL_TDE] | txd_wr;

    // a setting event outranks any clear in the same cycle
    flag_n = set_v | (flag_q & ~clr_v);
  end

  genvar g;
  generate
    for (g = 0; g < NFLAG; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q[g] <= FLAG_RST[g];
        else        flag_q[g] <= flag_n[g];
      end
    end
  endgenerate

  always_comb begin
    stat_byte = '0;
    for (int i = 0; i < NFLAG; i++) begin
      stat_byte[FLAG_POS[i]] = flag_q[i];
    end
  end

  assign irq_set = rx_trig & ctrl_rie;
  assign irq_clr = (ctrl_wr & ~wdata[CB_RIE]) |
                   (stat_wr & (~wdata[FLAG_POS[FL_RDF]] | ~wdata[FLAG_POS[FL_DR]]));

  always_comb begin
    irq_n = rx_irq;
    if (irq_clr) irq_n = 1'b0;
    if (irq_set) irq_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_irq <= 1'b0;
    else        rx_irq <= irq_n;
  end

  AST_BREAK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    line_break |=> stat_byte[4]); // R9
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && stat_wr) |=> stat_byte[6]); // R11
  AST_READ_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && ctrl_te) |=> (stat_byte[5] && stat_byte[6])); // R8
  AST_TDE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_wr && !rearm) |=> !stat_byte[5]); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_byte[7] == 1'b0 && stat_byte[3:2] == 2'b00)); // R6
  AST_RXIRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !wdata[1] && !rx_trig) |=> !rx_irq); // R7

endmodule

// File: rtl/serport_regs.sv
module serport_regs
  import serport_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_rd,
  output logic [7:0]        reg_rdata,
  output logic              tx_stb,
  output logic [7:0]        tx_byte,
  output logic              tx_irq,
  output logic              rx_irq,
  output logic              rx_en,
  input  logic              line_break,
  input  logic              tx_done,
  input  logic              rx_trig,
  input  logic              rx_dready
);

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_TXD  = ADDR_W'(OFF_TXD);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFF_MODE);
  localparam logic [ADDR_W-1:0] A_LINE = ADDR_W'(OFF_LINE);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_l = rs_q[1];

  logic [NCFG-1:0][7:0] cfg_q;
  logic [NCFG-1:0]      cfg_hit;
  logic                 stat_hit;
  logic                 txd_hit;
  logic [7:0]           stat_byte;
  logic [7:0]           ctrl_q;

  assign stat_hit = (reg_addr == A_STAT);
  assign txd_hit  = (reg_addr == A_TXD);

  genvar g;
  generate
    for (g = 0; g < NCFG; g++) begin : g_cfg
      assign cfg_hit[g] = (reg_addr == ADDR_W'(CFG_OFF[g]));
      serport_mreg #(
        .W    (REG_W),
        .MASK (CFG_MASK[g]),
        .RST  (CFG_RST[g])
      ) u_reg (
        .clk   (clk),
        .rst_n (rst_l),
        .we    (reg_wr & cfg_hit[g]),
        .wdata (reg_wdata),
        .q     (cfg_q[g])
      );
    end
  endgenerate

  assign ctrl_q = cfg_q[CFG_CTRL];
  assign tx_irq = ctrl_q[CB_TIE];
  assign rx_en  = ctrl_q[CB_RE];

  serport_status u_status (
    .clk        (clk),
    .rst_n      (rst_l),
    .stat_wr    (reg_wr & stat_hit),
    .stat_rd    (reg_rd & stat_hit),
    .wdata      (reg_wdata),
    .ctrl_wr    (reg_wr & cfg_hit[CFG_CTRL]),
    .txd_wr     (reg_wr & txd_hit),
    .ctrl_te    (ctrl_q[CB_TE]),
    .ctrl_rie   (ctrl_q[CB_RIE]),
    .line_break (line_break),
    .tx_done    (tx_done),
    .rx_trig    (rx_trig),
    .rx_dready  (rx_dready),
    .stat_byte  (stat_byte),
    .rx_irq     (rx_irq)
  );

  serport_txdata #(.W(REG_W)) u_txd (
    .clk     (clk),
    .rst_n   (rst_l),
    .we      (reg_wr & txd_hit),
    .wdata   (reg_wdata),
    .tx_stb  (tx_stb),
    .tx_byte (tx_byte)
  );

  // read mux: zero when idle and for every offset not listed here
  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      for (int i = 0; i < NCFG; i++) begin
        if (cfg_hit[i]) reg_rdata = cfg_q[i];
      end
      if (stat_hit) reg_rdata = stat_byte;
    end
  end

  AST_MODE_MASKED: assert property (@(posedge clk) disable iff (!rst_l)
    (reg_rd && reg_addr == A_MODE) |-> ((reg_rdata & ~CFG_MASK[CFG_MODE]) == 8'h00)); // R2
  AST_TXIRQ_TRACK: assert property (@(posedge clk) disable iff (!rst_l)
    (reg_wr && reg_addr == A_CTRL) |=> (tx_irq == $past(reg_wdata[7]))); // R4
  AST_RXEN_TRACK: assert property (@(posedge clk) disable iff (!rst_l)
    (reg_wr && reg_addr == A_CTRL) |=> (rx_en == $past(reg_wdata[4]))); // R12
  AST_LINE_ZERO: assert property (@(posedge clk) disable iff (!rst_l)
    (reg_rd && (reg_addr == A_LINE || reg_addr == A_TXD)) |-> (reg_rdata == 8'h00)); // R10

endmodule

// File: tb/serport_regs_tb.sv
module serport_regs_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       tx_stb;
  logic [7:0] tx_byte;
  logic       tx_irq;
  logic       rx_irq;
  logic       rx_en;
  logic       line_break = 1'b0;
  logic       tx_done = 1'b0;
  logic       rx_trig = 1'b0;
  logic       rx_dready = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serport_regs #(.ADDR_W(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .tx_stb(tx_stb), .tx_byte(tx_byte), .tx_irq(tx_irq), .rx_irq(rx_irq),
    .rx_en(rx_en), .line_break(line_break), .tx_done(tx_done),
    .rx_trig(rx_trig), .rx_dready(rx_dready)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 chk(req, reg_rdata, exp);
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: line_break = 1'b1;
      1: tx_done    = 1'b1;
      2: rx_trig    = 1'b1;
      default: rx_dready = 1'b1;
    endcase
    @(posedge clk); #1;
    line_break = 1'b0; tx_done = 1'b0; rx_trig = 1'b0; rx_dready = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk("R1 mode", 6'h00, 8'h00);
    rd_chk("R1 rate", 6'h04, 8'hFF);
    rd_chk("R1 ctrl", 6'h08, 8'h20);
    rd_chk("R1 pin",  6'h20, 8'h00);
    rd_chk("R1 status", 6'h10, 8'h60);
    chk("R1 outputs", {4'h0, tx_irq, rx_irq, rx_en, tx_stb}, 8'h00);
  endtask

  task automatic t_masks();
    wr(6'h00, 8'hFF); rd_chk("R2 mode mask", 6'h00, 8'h7B);
    wr(6'h04, 8'h5A); rd_chk("R2 rate", 6'h04, 8'h5A);
    wr(6'h20, 8'hFF); rd_chk("R2 pin mask", 6'h20, 8'hF3);
    wr(6'h08, 8'hFF); rd_chk("R2 ctrl mask", 6'h08, 8'hFA);
    chk("R4 tx_irq high", {7'h0, tx_irq}, 8'h01);
    chk("R12 rx_en high", {7'h0, rx_en}, 8'h01);
    wr(6'h08, 8'h00);
    chk("R4 tx_irq low", {7'h0, tx_irq}, 8'h00);
    chk("R12 rx_en low", {7'h0, rx_en}, 8'h00);
  endtask

  task automatic t_tend();
    wr(6'h10, 8'h00);
    rd_chk("R8 no rearm with tx off", 6'h10, 8'h00);
    rd_chk("R8 still clear", 6'h10, 8'h00);
    wr(6'h08, 8'h80);
    rd_chk("R3 tx-end set by ctrl write", 6'h10, 8'h40);
    wr(6'h08, 8'h00);
  endtask

  task automatic t_rearm();
    wr(6'h08, 8'h20);
    wr(6'h10, 8'h00);
    rd_chk("R8 read returns old flags", 6'h10, 8'h00);
    rd_chk("R8 flags rearmed", 6'h10, 8'h60);
    wr(6'h08, 8'h00);
  endtask

  task automatic t_txdata();
    wr(6'h0C, 8'hA5);
    chk("R5 strobe", {7'h0, tx_stb}, 8'h01);
    chk("R5 byte", tx_byte, 8'hA5);
    @(posedge clk); #1;
    chk("R5 strobe one cycle", {7'h0, tx_stb}, 8'h00);
    chk("R5 byte held", tx_byte, 8'hA5);
    rd_chk("R5 tx-empty cleared", 6'h10, 8'h40);
    rd_chk("R10 tx data reads zero", 6'h0C, 8'h00);
  endtask

  task automatic t_rx();
    wr(6'h08, 8'h40);
    wr(6'h10, 8'h00);
    pulse(0); pulse(2); pulse(3); pulse(1);
    chk("R7 rx_irq raised", {7'h0, rx_irq}, 8'h01);
    rd_chk("R9 R6 all events", 6'h10, 8'h53);
    wr(6'h10, 8'hFD);
    chk("R7 rx_irq dropped", {7'h0, rx_irq}, 8'h00);
    rd_chk("R6 clear trigger only", 6'h10, 8'h51);
    wr(6'h10, 8'hEF); rd_chk("R6 clear break only", 6'h10, 8'h41);
    wr(6'h10, 8'hFE); rd_chk("R6 clear ready only", 6'h10, 8'h40);
    wr(6'h10, 8'hBF); rd_chk("R6 clear tx-end", 6'h10, 8'h00);
    wr(6'h10, 8'hFF); rd_chk("R6 ones keep", 6'h10, 8'h00);
  endtask

  task automatic t_rxirq();
    pulse(2);
    chk("R7 irq on trigger", {7'h0, rx_irq}, 8'h01);
    wr(6'h08, 8'h00);
    chk("R4 ctrl drops rx_irq", {7'h0, rx_irq}, 8'h00);
    pulse(2);
    chk("R7 no irq when disabled", {7'h0, rx_irq}, 8'h00);
    rd_chk("R7 trigger flag set", 6'h10, 8'h42);
    wr(6'h08, 8'h40);
    pulse(2);
    wr(6'h10, 8'hFE);
    chk("R7 ready-bit write drops irq", {7'h0, rx_irq}, 8'h00);
  endtask

  task automatic t_evt_wins();
    wr(6'h08, 8'h00);
    wr(6'h10, 8'h00);
    @(negedge clk);
    reg_addr = 6'h10; reg_wdata = 8'h00; reg_wr = 1'b1;
    line_break = 1'b1; tx_done = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0; line_break = 1'b0; tx_done = 1'b0;
    rd_chk("R11 events beat clear", 6'h10, 8'h50);
  endtask

  task automatic t_unmapped();
    wr(6'h24, 8'hFF);
    wr(6'h14, 8'h00);
    wr(6'h3C, 8'h55);
    rd_chk("R10 line reg zero", 6'h24, 8'h00);
    rd_chk("R10 unmapped zero", 6'h3C, 8'h00);
    rd_chk("R10 mode kept", 6'h00, 8'h7B);
    rd_chk("R10 rate kept", 6'h04, 8'h5A);
    rd_chk("R10 pin kept", 6'h20, 8'hF3);
    rd_chk("R10 ctrl kept", 6'h08, 8'h00);
    rd_chk("R10 status kept", 6'h10, 8'h50);
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_masks();
    t_tend();
    t_rearm();
    t_txdata();
    t_rx();
    t_rxirq();
    t_evt_wins();
    t_unmapped();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule